// File: doc/BRIEF.md
# Per-Port Reset Assertion Controller

This block carries out the physical-port reset command of a multi-port switch's management engine. A request names a port slot and an operation, and carries a payload length. The engine checks the request and answers with a status code. An accepted request either asserts or releases that port's fundamental reset, or fires a one-cycle cold-reset pulse at it.

Each port slot holds its own reset state, its own hold counter and a link flag that reports reset asserted. An assert takes effect at once. It completes only after a hold of `HOLD_MS` millisecond ticks. Until then the port refuses every other operation. A free-running prescaler makes the millisecond tick from the system clock. Only ports marked active at reset ever accept a command.

Top module: `port_rst_ctl`

## Requirements
- R1: A request with `req_len` below 2 returns status 2 (invalid length) and changes no port output.
- R2: A port identifier that is not below `NUM_PORTS`, or that differs from the identifier configured for that slot in `cfg_id`, returns status 3 (internal error).
- R3: A slot whose role code in `cfg_role` is neither 2'b01 (upstream) nor 2'b10 (downstream) returns status 3. The checks of R2 and R3 come before the operation is decoded, so a bad port with a bad operation still returns status 3.
- R4: On a valid port, an operation byte other than 0 (assert), 1 (deassert) or 2 (cold reset) returns status 1 (invalid input).
- R5: An accepted assert returns status 0. The port's `perst` bit and `link_rst_flag` bit are high from the response edge onward.
- R6: Assert and cold reset return status 3 while the port's hold is running or after it has completed, and they leave the outputs unchanged.
- R7: The hold completes after `HOLD_MS` ticks of the prescaler, which fires once every `TICK_DIV` cycles. A deassert issued before completion returns status 3 and leaves `perst` high.
- R8: A deassert after completion returns status 0 and clears `perst` and `link_rst_flag`. It also reloads the hold counter, so a following assert is accepted.
- R9: An accepted cold reset returns status 0 and raises `cold_rst` for that port alone for exactly one cycle. The reset state of the port does not change.
- R10: A port whose bit in `active_mask` was clear during reset refuses assert, deassert and cold reset with status 3.
- R11: Every request gets exactly one `rsp_done` pulse on the clock edge that samples it. The status codes are 0 success, 1 invalid input, 2 invalid length and 3 internal error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| active_mask | input | NUM_PORTS | Slots enabled at reset, bit p for slot p |
| cfg_id | input | NUM_PORTS*8 | Configured identifier for each slot, slot p in bits [8p+7:8p] |
| cfg_role | input | NUM_PORTS*2 | Role code per slot, 01 upstream, 10 downstream |
| req_valid | input | 1 | Request strobe, one cycle |
| req_len | input | 2 | Payload length in bytes, saturated at 3 |
| req_port | input | 8 | Payload byte 0, port identifier |
| req_op | input | 8 | Payload byte 1, operation |
| rsp_done | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | Response status code |
| perst | output | NUM_PORTS | Fundamental reset per port, active high |
| link_rst_flag | output | NUM_PORTS | Link-state flag for reset asserted, per port |
| cold_rst | output | NUM_PORTS | One-cycle cold-reset pulse per port |

## Verification
A request is sampled on one rising edge, and its status, the new `perst` and link flag, and any cold pulse all appear on that same edge. The bench therefore drives each request at a falling edge and reads every result at the next falling edge, with a scoreboard queue popped by a monitor on `rsp_done`. The cold pulse is checked high at that falling edge and low one cycle later. Hold completion has a window of up to one tick of slack, because the prescaler runs freely. A deassert is therefore tried well before the earliest possible completion and again after the latest.

// File: rtl/port_rst_pkg.sv
package port_rst_pkg;

    typedef enum logic [1:0] {
        ST_OK       = 2'd0,
        ST_BAD_IN   = 2'd1,
        ST_BAD_LEN  = 2'd2,
        ST_INTERNAL = 2'd3
    } status_e;

    localparam logic [7:0] OP_ASSERT   = 8'd0;
    localparam logic [7:0] OP_DEASSERT = 8'd1;
    localparam logic [7:0] OP_COLD     = 8'd2;

    localparam logic [1:0] ROLE_UP   = 2'b01;
    localparam logic [1:0] ROLE_DOWN = 2'b10;

    localparam logic [1:0] MIN_LEN = 2'd2;

    function automatic logic role_usable(input logic [1:0] role);
        return (role == ROLE_UP) || (role == ROLE_DOWN);
    endfunction

endpackage

// File: rtl/ms_tick_gen.sv
module ms_tick_gen #(
    parameter int TICK_DIV = 100000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (TICK_DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(TICK_DIV);
            localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst)              cnt <= '0;
                else if (cnt == LAST) cnt <= '0;
                else                  cnt <= cnt + 1'b1;
            end
            assign tick = (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/port_slot.sv
module port_slot #(
    parameter int HOLD_MS = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic tick,
    input  logic do_assert,
    input  logic do_deassert,
    input  logic do_cold,
    output logic ready,
    output logic complete,
    output logic perst,
    output logic cold_pulse
);
    localparam int HW = $clog2(HOLD_MS + 1);
    localparam logic [HW-1:0] FULL = HW'(HOLD_MS);

    logic [HW-1:0] hold_cnt;
    logic          asrt_q;
    logic          done_q;
    logic          cold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            asrt_q   <= 1'b0;
            done_q   <= 1'b0;
            cold_q   <= 1'b0;
            hold_cnt <= active ? FULL : '0;
        end else begin
            cold_q <= do_cold;
            if (do_assert) begin
                asrt_q <= 1'b1;
            end else if (do_deassert) begin
                asrt_q   <= 1'b0;
                done_q   <= 1'b0;
                hold_cnt <= FULL;
            end else if (asrt_q && !done_q && tick) begin
                hold_cnt <= hold_cnt - 1'b1;
                if (hold_cnt <= HW'(1)) done_q <= 1'b1;
            end
        end
    end

    // idle, not holding, counter fully loaded
    assign ready      = !asrt_q && (hold_cnt == FULL);
    assign complete   = done_q;
    assign perst      = asrt_q;
    assign cold_pulse = cold_q;
endmodule

// File: rtl/port_rst_ctl.sv
module port_rst_ctl
    import port_rst_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int TICK_DIV  = 100000,
    parameter int HOLD_MS   = 100
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_PORTS-1:0]   active_mask,
    input  logic [NUM_PORTS*8-1:0] cfg_id,
    input  logic [NUM_PORTS*2-1:0] cfg_role,
    input  logic                   req_valid,
    input  logic [1:0]             req_len,
    input  logic [7:0]             req_port,
    input  logic [7:0]             req_op,
    output logic                   rsp_done,
    output logic [1:0]             rsp_status,
    output logic [NUM_PORTS-1:0]   perst,
    output logic [NUM_PORTS-1:0]   link_rst_flag,
    output logic [NUM_PORTS-1:0]   cold_rst
);
    logic tick;
    logic [NUM_PORTS-1:0] slot_ready, slot_done;
    logic [NUM_PORTS-1:0] go_assert, go_deassert, go_cold;

    ms_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    logic       in_range;
    logic [7:0] sel_id;
    logic [1:0] sel_role;
    logic       sel_ready, sel_done;
    status_e    verdict;

    always_comb begin
        in_range  = (32'(req_port) < NUM_PORTS);
        sel_id    = '0;
        sel_role  = '0;
        sel_ready = 1'b0;
        sel_done  = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (32'(req_port) == p) begin
                sel_id    = cfg_id[p*8 +: 8];
                sel_role  = cfg_role[p*2 +: 2];
                sel_ready = slot_ready[p];
                sel_done  = slot_done[p];
            end
        end

        if (req_len < MIN_LEN) begin
            verdict = ST_BAD_LEN;
        end else if (!in_range || sel_id != req_port || !role_usable(sel_role)) begin
            verdict = ST_INTERNAL;
        end else begin
            unique case (req_op)
                OP_ASSERT:   verdict = sel_ready ? ST_OK : ST_INTERNAL;
                OP_DEASSERT: verdict = sel_done  ? ST_OK : ST_INTERNAL;
                OP_COLD:     verdict = sel_ready ? ST_OK : ST_INTERNAL;
                default:     verdict = ST_BAD_IN;
            endcase
        end
    end

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_slot
            logic hit;
            assign hit = req_valid && (verdict == ST_OK) && (32'(req_port) == p);
            assign go_assert[p]   = hit && (req_op == OP_ASSERT);
            assign go_deassert[p] = hit && (req_op == OP_DEASSERT);
            assign go_cold[p]     = hit && (req_op == OP_COLD);

            port_slot #(.HOLD_MS(HOLD_MS)) u_slot (
                .clk        (clk),
                .rst        (rst),
                .active     (active_mask[p]),
                .tick       (tick),
                .do_assert  (go_assert[p]),
                .do_deassert(go_deassert[p]),
                .do_cold    (go_cold[p]),
                .ready      (slot_ready[p]),
                .complete   (slot_done[p]),
                .perst      (perst[p]),
                .cold_pulse (cold_rst[p])
            );
        end
    endgenerate

    // the link flag follows the per-port reset state
    assign link_rst_flag = perst;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_done   <= 1'b0;
            rsp_status <= ST_OK;
        end else begin
            rsp_done <= req_valid;
            if (req_valid) rsp_status <= verdict;
        end
    end
endmodule

// File: rtl/port_rst_ctl_chk.sv
module port_rst_ctl_chk #(
    parameter int NUM_PORTS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic [1:0]           req_len,
    input logic [7:0]           req_op,
    input logic                 rsp_done,
    input logic [1:0]           rsp_status,
    input logic [NUM_PORTS-1:0] perst,
    input logic [NUM_PORTS-1:0] cold_rst
);
    p_len_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_len < 2'd2) |=> (rsp_done && rsp_status == 2'd2));

    p_one_rsp_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_done);

    p_no_spurious_r11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_done);

    p_perst_rise_r5: assert property (@(posedge clk) disable iff (rst)
        ((perst & ~$past(perst)) != '0) |->
            ($past(req_valid) && $past(req_op) == 8'd0 && rsp_status == 2'd0));

    p_perst_fall_r8: assert property (@(posedge clk) disable iff (rst)
        (($past(perst) & ~perst) != '0) |->
            ($past(req_valid) && $past(req_op) == 8'd1 && rsp_status == 2'd0));

    p_cold_single_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cold_rst));

    p_cold_status_r9: assert property (@(posedge clk) disable iff (rst)
        (cold_rst != '0) |-> (rsp_done && rsp_status == 2'd0 && $stable(perst)));
endmodule

bind port_rst_ctl port_rst_ctl_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_len   (req_len),
    .req_op    (req_op),
    .rsp_done  (rsp_done),
    .rsp_status(rsp_status),
    .perst     (perst),
    .cold_rst  (cold_rst)
);

// File: tb/tb_port_rst_ctl.sv
module tb_port_rst_ctl;
    localparam int NP   = 5;
    localparam int DIV  = 4;
    localparam int HOLD = 5;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NP-1:0]   active_mask = 5'b01111;
    logic [NP*8-1:0] cfg_id   = {8'd4, 8'd7, 8'd2, 8'd1, 8'd0};
    logic [NP*2-1:0] cfg_role = {2'b10, 2'b10, 2'b11, 2'b10, 2'b01};
    logic            req_valid = 1'b0;
    logic [1:0]      req_len = '0;
    logic [7:0]      req_port = '0;
    logic [7:0]      req_op = '0;
    logic            rsp_done;
    logic [1:0]      rsp_status;
    logic [NP-1:0]   perst, link_rst_flag, cold_rst;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [1:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    port_rst_ctl #(.NUM_PORTS(NP), .TICK_DIV(DIV), .HOLD_MS(HOLD)) dut (
        .clk(clk), .rst(rst), .active_mask(active_mask), .cfg_id(cfg_id),
        .cfg_role(cfg_role), .req_valid(req_valid), .req_len(req_len),
        .req_port(req_port), .req_op(req_op), .rsp_done(rsp_done),
        .rsp_status(rsp_status), .perst(perst), .link_rst_flag(link_rst_flag),
        .cold_rst(cold_rst)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on each response
    always @(negedge clk) begin
        if (!rst && rsp_done) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected response", 32'(rsp_done), 32'd0);
            end else begin
                check(tag_q.pop_front(), 32'(rsp_status), 32'(exp_q.pop_front()));
            end
        end
    end

    task automatic send(input logic [7:0] port, input logic [7:0] op,
                        input logic [1:0] len, input logic [1:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_port = port; req_op = op; req_len = len;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 reset rsp_done", 32'(rsp_done), 32'd0);
        check("R5 reset perst", 32'(perst), 32'd0);
        check("R5 reset link flag", 32'(link_rst_flag), 32'd0);

        send(8'd0, 8'd0, 2'd1, 2'd2, "R1 short payload");
        check("R1 no perst change", 32'(perst), 32'd0);
        send(8'd0, 8'd0, 2'd0, 2'd2, "R1 empty payload");
        send(8'd0, 8'd3, 2'd2, 2'd1, "R4 op 3");
        send(8'd1, 8'hff, 2'd3, 2'd1, "R4 op ff");
        send(8'd9, 8'd0, 2'd2, 2'd3, "R2 port out of range");
        send(8'd3, 8'd0, 2'd2, 2'd3, "R2 id mismatch");
        send(8'd2, 8'd0, 2'd2, 2'd3, "R3 bad role");
        send(8'd2, 8'd7, 2'd2, 2'd3, "R3 port check before op");
        send(8'd0, 8'd1, 2'd2, 2'd3, "R7 deassert while idle");
        check("R2 no perst change", 32'(perst), 32'd0);

        send(8'd4, 8'd0, 2'd2, 2'd3, "R10 inactive assert");
        send(8'd4, 8'd2, 2'd2, 2'd3, "R10 inactive cold");
        send(8'd4, 8'd1, 2'd2, 2'd3, "R10 inactive deassert");
        check("R10 no cold pulse", 32'(cold_rst), 32'd0);

        send(8'd1, 8'd0, 2'd2, 2'd0, "R5 assert port1");
        check("R5 perst port1", 32'(perst), 32'b00010);
        check("R5 link flag port1", 32'(link_rst_flag), 32'b00010);
        send(8'd1, 8'd0, 2'd2, 2'd3, "R6 re-assert in hold");
        send(8'd1, 8'd2, 2'd2, 2'd3, "R6 cold in hold");
        check("R6 no cold pulse", 32'(cold_rst), 32'd0);
        send(8'd1, 8'd1, 2'd2, 2'd3, "R7 early deassert");
        check("R7 perst held", 32'(perst), 32'b00010);
        repeat (24) @(negedge clk);
        send(8'd1, 8'd0, 2'd2, 2'd3, "R6 assert after complete");
        send(8'd1, 8'd1, 2'd2, 2'd0, "R8 deassert after hold");
        check("R8 perst cleared", 32'(perst), 32'd0);
        check("R8 link flag cleared", 32'(link_rst_flag), 32'd0);
        send(8'd1, 8'd0, 2'd3, 2'd0, "R8 assert after reload");
        check("R8 perst again", 32'(perst), 32'b00010);

        send(8'd0, 8'd2, 2'd2, 2'd0, "R9 cold port0");
        check("R9 cold pulse high", 32'(cold_rst), 32'b00001);
        check("R9 perst unchanged", 32'(perst), 32'b00010);
        @(negedge clk);
        check("R9 cold pulse one cycle", 32'(cold_rst), 32'd0);
        send(8'd0, 8'd0, 2'd2, 2'd0, "R5 assert port0 after cold");
        check("R5 both ports held", 32'(perst), 32'b00011);

        repeat (4) @(negedge clk);
        check("R11 scoreboard drained", 32'(exp_q.size()), 32'd0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(negedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule